// File: doc/BRIEF.md
# Mirrored Variable Store with Read-Time Consistency Check

This block keeps every protected program variable twice, once in each of two physically separate register banks. A processor-side write by variable index stores the value in both banks at the same clock edge. Every read by index fetches both copies and compares them. The value from bank 0 comes back together with a mismatch flag. Bank 1 holds its copy bit-inverted, so a fault that forces the same raw pattern into both banks still shows up as a difference.

A second lookup port, the condition port, serves operands that decide a branch or a loop exit. It is checked in the same way and independently of the ordinary read port. Procedure arguments and return values are stored as ordinary indexed variables; they need no special handling.

The first failing index is captured in an error register next to a sticky error flag and a bit that tells which port found it. Software clears the flag with an explicit clear input. A fault-injection input forces a raw pattern into either bank or both, so that upsets can be rehearsed. A corrupted copy is only noticed when that variable is read again. Damage after its last read stays silent.

Top module: `dupvar_guard`

## Requirements
- R1: After reset every output is 0, and every variable reads back as 0 with no mismatch.
- R2: A write stores the value in both banks. A read request in cycle t gives `rd_valid`=1 and `rd_data` equal to the stored value after the next rising edge, with `rd_mismatch`=0 when the copies agree. `rd_valid` is 0 after a cycle with no read request.
- R3: When the bank 0 value differs from the decoded bank 1 value, the read gives `rd_mismatch`=1 with the same latency, and `rd_data` still carries the bank 0 value.
- R4: The condition port (`cond_en`, `cond_idx`) gives `cond_valid`, `cond_data` and `cond_mismatch` with the same timing and rules as the read port, independently of it.
- R5: Any mismatch sets `err_flag` at the same edge that raises the mismatch output. While the flag stays set, it holds, and so do `err_idx` and `err_on_cond`, whatever later mismatches occur.
- R6: `err_clear` with no mismatch in that cycle sets `err_flag`, `err_idx` and `err_on_cond` to 0 at the next edge. `err_clear` in a cycle that also finds a mismatch leaves the flag set and captures the new index.
- R7: A write and a read of the same index in one cycle return the new value with no mismatch, even if the old copies disagreed.
- R8: When both ports find a mismatch in the same cycle and a new capture takes place, the read port wins: `err_idx` gets `rd_idx` and `err_on_cond`=0. `err_on_cond`=1 only for a capture made by the condition port alone.
- R9: Bank 1 stores the bitwise inverse of the value. Forcing the same raw pattern into both banks at one index with `inj_bank_sel`=2'b11 makes the next read of that index report a mismatch.
- R10: A write to a corrupted index repairs both copies, and later reads of it report no mismatch. At one edge a write takes priority over an injection into the same index.
- R11: An injection into a variable that is never read raises neither a mismatch output nor `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Index of the variable written |
| wr_data | input | DATA_W | Value written to both banks |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Index of the variable read |
| rd_valid | output | 1 | Read result valid (one cycle after request) |
| rd_data | output | DATA_W | Bank 0 value of the variable read |
| rd_mismatch | output | 1 | The copies differed on this read |
| cond_en | input | 1 | Condition-operand lookup request |
| cond_idx | input | IDX_W | Index of the condition operand |
| cond_valid | output | 1 | Condition result valid |
| cond_data | output | DATA_W | Bank 0 value of the condition operand |
| cond_mismatch | output | 1 | The copies differed on the condition lookup |
| err_clear | input | 1 | Clears the captured error |
| err_flag | output | 1 | Sticky error flag |
| err_idx | output | IDX_W | Index of the first failing variable |
| err_on_cond | output | 1 | 1 when the condition port made the capture |
| inj_en | input | 1 | Fault injection enable |
| inj_bank_sel | input | 2 | Banks receiving the injection (bit 0 bank 0, bit 1 bank 1) |
| inj_idx | input | IDX_W | Index receiving the injection |
| inj_raw | input | DATA_W | Raw pattern forced into the selected banks |

## Verification
The bench builds the block with 8 variables of 12 bits, against defaults of 16 by 16. With so few indices, random writes, reads, condition lookups and injections often land on the same variable in the same cycle. That brings the write-to-read bypass, dual-port mismatch priority and repair-after-corruption cases within reach of random traffic as well as of the directed cases. Forcing the same raw pattern into both banks at once tests the inverted storage of bank 1, which plain bit-flip traffic cannot show.

// File: rtl/dupvar_pkg.sv
package dupvar_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic [0:0] {
    PORT_RD   = 1'b0,
    PORT_COND = 1'b1
  } port_e;
endpackage

// File: rtl/dupvar_bank.sv
module dupvar_bank
  import dupvar_pkg::*;
#(
  parameter int unsigned NUM_VARS = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter bit          INVERT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frc_en,
  input  logic [IDX_W-1:0]  frc_idx,
  input  logic [DATA_W-1:0] frc_raw,
  input  logic [IDX_W-1:0]  lk_idx [NUM_PORTS],
  output logic [DATA_W-1:0] lk_val [NUM_PORTS]
);
  localparam logic [DATA_W-1:0] RST_RAW = INVERT ? '1 : '0;

  logic [DATA_W-1:0] enc_wr;
  logic [DATA_W-1:0] cell_q [NUM_VARS];

  // stored encoding: true or inverted, chosen per bank
  generate
    if (INVERT) begin : g_inv
      assign enc_wr = ~wr_data;
    end else begin : g_true
      assign enc_wr = wr_data;
    end
  endgenerate

  for (genvar v = 0; v < NUM_VARS; v++) begin : g_cell
    logic              wr_hit;
    logic              frc_hit;
    logic              cell_en;
    logic [DATA_W-1:0] cell_d;

    always_comb begin
      wr_hit  = wr_en  && (wr_idx  == IDX_W'(v));
      frc_hit = frc_en && (frc_idx == IDX_W'(v));
      cell_en = wr_hit || frc_hit;
      // a write overrides an injection landing on the same cell
      cell_d  = wr_hit ? enc_wr : frc_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[v] <= RST_RAW;
      end else if (cell_en) begin
        cell_q[v] <= cell_d;
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lookup
    logic [DATA_W-1:0] raw;
    logic              in_range;
    always_comb begin
      in_range = ({1'b0, lk_idx[p]} < (IDX_W+1)'(NUM_VARS));
      raw      = in_range ? cell_q[lk_idx[p]] : RST_RAW;
      lk_val[p] = INVERT ? ~raw : raw;
    end
  end
endmodule

// File: rtl/dupvar_port_check.sv
module dupvar_port_check #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] val0,
  input  logic [DATA_W-1:0] val1,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_now,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_mism
);
  logic              byp;
  logic [DATA_W-1:0] data_d;
  logic              valid_q;
  logic              mism_q;
  logic [DATA_W-1:0] data_q;

  // next-state: bypass the write, else compare both decoded copies
  always_comb begin
    byp     = wr_en && (wr_idx == req_idx);
    data_d  = byp ? wr_data : val0;
    hit_now = req_en && !byp && (val0 != val1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mism_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= req_en;
      mism_q  <= hit_now;
      if (req_en) begin
        data_q <= data_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_mism  = mism_q;
endmodule

// File: rtl/dupvar_err_latch.sv
module dupvar_err_latch
  import dupvar_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hit_rd,
  input  logic [IDX_W-1:0] idx_rd,
  input  logic             hit_cond,
  input  logic [IDX_W-1:0] idx_cond,
  output logic             err_flag,
  output logic [IDX_W-1:0] err_idx,
  output logic             err_on_cond
);
  logic             flag_q, flag_d;
  logic [IDX_W-1:0] idx_q,  idx_d;
  port_e            src_q,  src_d;
  logic             upd;

  always_comb begin
    flag_d = flag_q;
    idx_d  = idx_q;
    src_d  = src_q;
    upd    = 1'b0;
    if (hit_rd || hit_cond) begin
      upd    = 1'b1;
      flag_d = 1'b1;
      if (!flag_q || clear) begin
        // read port has priority over the condition port
        idx_d = hit_rd ? idx_rd : idx_cond;
        src_d = hit_rd ? PORT_RD : PORT_COND;
      end
    end else if (clear) begin
      upd    = 1'b1;
      flag_d = 1'b0;
      idx_d  = '0;
      src_d  = PORT_RD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      idx_q  <= '0;
      src_q  <= PORT_RD;
    end else if (upd) begin
      flag_q <= flag_d;
      idx_q  <= idx_d;
      src_q  <= src_d;
    end
  end

  assign err_flag    = flag_q;
  assign err_idx     = idx_q;
  assign err_on_cond = (src_q == PORT_COND);
endmodule

// File: rtl/dupvar_guard.sv
module dupvar_guard
  import dupvar_pkg::*;
#(
  parameter int unsigned NUM_VARS = 16,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned IDX_W   = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mismatch,
  input  logic              cond_en,
  input  logic [IDX_W-1:0]  cond_idx,
  output logic              cond_valid,
  output logic [DATA_W-1:0] cond_data,
  output logic              cond_mismatch,
  input  logic              err_clear,
  output logic              err_flag,
  output logic [IDX_W-1:0]  err_idx,
  output logic              err_on_cond,
  input  logic              inj_en,
  input  logic [1:0]        inj_bank_sel,
  input  logic [IDX_W-1:0]  inj_idx,
  input  logic [DATA_W-1:0] inj_raw
);
  logic [IDX_W-1:0]  lk_idx  [NUM_PORTS];
  logic              lk_en   [NUM_PORTS];
  logic [DATA_W-1:0] bank_val [NUM_BANKS][NUM_PORTS];
  logic              hit     [NUM_PORTS];
  logic              p_valid [NUM_PORTS];
  logic [DATA_W-1:0] p_data  [NUM_PORTS];
  logic              p_mism  [NUM_PORTS];

  assign lk_idx[PORT_RD]   = rd_idx;
  assign lk_idx[PORT_COND] = cond_idx;
  assign lk_en[PORT_RD]    = rd_en;
  assign lk_en[PORT_COND]  = cond_en;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dupvar_bank #(
      .NUM_VARS (NUM_VARS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .INVERT   (b == 1)
    ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .frc_en  (inj_en && inj_bank_sel[b]),
      .frc_idx (inj_idx),
      .frc_raw (inj_raw),
      .lk_idx  (lk_idx),
      .lk_val  (bank_val[b])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dupvar_port_check #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) chk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_en    (lk_en[p]),
      .req_idx   (lk_idx[p]),
      .val0      (bank_val[0][p]),
      .val1      (bank_val[1][p]),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .hit_now   (hit[p]),
      .out_valid (p_valid[p]),
      .out_data  (p_data[p]),
      .out_mism  (p_mism[p])
    );
  end

  dupvar_err_latch #(
    .IDX_W (IDX_W)
  ) err_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (err_clear),
    .hit_rd      (hit[PORT_RD]),
    .idx_rd      (rd_idx),
    .hit_cond    (hit[PORT_COND]),
    .idx_cond    (cond_idx),
    .err_flag    (err_flag),
    .err_idx     (err_idx),
    .err_on_cond (err_on_cond)
  );

  assign rd_valid      = p_valid[PORT_RD];
  assign rd_data       = p_data[PORT_RD];
  assign rd_mismatch   = p_mism[PORT_RD];
  assign cond_valid    = p_valid[PORT_COND];
  assign cond_data     = p_data[PORT_COND];
  assign cond_mismatch = p_mism[PORT_COND];
endmodule

// File: rtl/dupvar_guard_chk.sv
module dupvar_guard_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_mismatch,
  input logic              cond_en,
  input logic              cond_valid,
  input logic              cond_mismatch,
  input logic              err_clear,
  input logic              err_flag,
  input logic [IDX_W-1:0]  err_idx,
  input logic              err_on_cond
);
  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_rd_mism_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mismatch |-> err_flag);
  assert_cond_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_en |=> cond_valid);
  assert_cond_mism_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_mismatch |-> err_flag);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clear |=> err_flag);
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clear |=> $stable(err_idx) && $stable(err_on_cond));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (err_flag == (rd_mismatch || cond_mismatch)));
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && wr_en && (rd_idx == wr_idx) |=> !rd_mismatch && (rd_data == $past(wr_data)));
  assert_rd_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mismatch && cond_mismatch && (!$past(err_flag) || $past(err_clear)) |-> !err_on_cond);
endmodule

bind dupvar_guard dupvar_guard_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) chk_bind_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_data       (wr_data),
  .rd_en         (rd_en),
  .rd_idx        (rd_idx),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .rd_mismatch   (rd_mismatch),
  .cond_en       (cond_en),
  .cond_valid    (cond_valid),
  .cond_mismatch (cond_mismatch),
  .err_clear     (err_clear),
  .err_flag      (err_flag),
  .err_idx       (err_idx),
  .err_on_cond   (err_on_cond)
);

// File: tb/dupvar_guard_tb.sv
`timescale 1ns/1ps
module dupvar_guard_tb_top;
  localparam int NV = 8;
  localparam int DW = 12;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          rd_en;
  logic [IW-1:0] rd_idx;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_mismatch;
  logic          cond_en;
  logic [IW-1:0] cond_idx;
  logic          cond_valid;
  logic [DW-1:0] cond_data;
  logic          cond_mismatch;
  logic          err_clear;
  logic          err_flag;
  logic [IW-1:0] err_idx;
  logic          err_on_cond;
  logic          inj_en;
  logic [1:0]    inj_bank_sel;
  logic [IW-1:0] inj_idx;
  logic [DW-1:0] inj_raw;

  always #10 clk = ~clk;

  dupvar_guard #(.NUM_VARS(NV), .DATA_W(DW)) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model: raw contents of both banks and the error register
  logic [DW-1:0] m0 [NV];
  logic [DW-1:0] m1 [NV];
  logic          e_flag;
  logic [IW-1:0] e_idx;
  logic          e_cond;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = '0; wr_data = '0;
    rd_en = 0; rd_idx = '0; cond_en = 0; cond_idx = '0;
    err_clear = 0; inj_en = 0; inj_bank_sel = '0; inj_idx = '0; inj_raw = '0;
  endtask

  function automatic logic look_mism(input logic en, input logic [IW-1:0] i);
    if (!en) return 1'b0;
    if (wr_en && wr_idx == i) return 1'b0;
    return m0[i] != ~m1[i];
  endfunction

  function automatic logic [DW-1:0] look_data(input logic [IW-1:0] i);
    return (wr_en && wr_idx == i) ? wr_data : m0[i];
  endfunction

  // one clock: expected values from the model, edge, model update, check
  task automatic tick(input string tag);
    logic          x_rv, x_cv, x_rm, x_cm;
    logic [DW-1:0] x_rd, x_cd;
    x_rv = rd_en;   x_cv = cond_en;
    x_rm = look_mism(rd_en, rd_idx);
    x_cm = look_mism(cond_en, cond_idx);
    x_rd = look_data(rd_idx);
    x_cd = look_data(cond_idx);
    if (x_rm || x_cm) begin
      if (!e_flag || err_clear) begin
        e_idx  = x_rm ? rd_idx : cond_idx;
        e_cond = !x_rm;
      end
      e_flag = 1'b1;
    end else if (err_clear) begin
      e_flag = 0; e_idx = '0; e_cond = 0;
    end
    @(posedge clk);
    if (inj_en && inj_bank_sel[0]) m0[inj_idx] = inj_raw;
    if (inj_en && inj_bank_sel[1]) m1[inj_idx] = inj_raw;
    if (wr_en) begin
      m0[wr_idx] = wr_data;
      m1[wr_idx] = ~wr_data;
    end
    @(negedge clk);
    chk(tag, "R2 rd_valid", int'(rd_valid), int'(x_rv));
    if (x_rv) begin
      chk(tag, "R2 rd_data", int'(rd_data), int'(x_rd));
      chk(tag, "R3 rd_mismatch", int'(rd_mismatch), int'(x_rm));
    end
    chk(tag, "R4 cond_valid", int'(cond_valid), int'(x_cv));
    if (x_cv) begin
      chk(tag, "R4 cond_data", int'(cond_data), int'(x_cd));
      chk(tag, "R4 cond_mismatch", int'(cond_mismatch), int'(x_cm));
    end
    chk(tag, "R5 err_flag", int'(err_flag), int'(e_flag));
    chk(tag, "R5 err_idx", int'(err_idx), int'(e_idx));
    chk(tag, "R8 err_on_cond", int'(err_on_cond), int'(e_cond));
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    for (int i = 0; i < NV; i++) begin m0[i] = '0; m1[i] = '1; end
    e_flag = 0; e_idx = '0; e_cond = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "err_flag", int'(err_flag), 0);
    chk("R1", "err_idx", int'(err_idx), 0);
    chk("R1", "cond_valid", int'(cond_valid), 0);
    for (int i = 0; i < NV; i++) begin
      rd_en = 1; rd_idx = IW'(i); cond_en = 1; cond_idx = IW'(NV-1-i);
      tick("R1");
    end
    // R2: plain write then read
    wr_en = 1; wr_idx = 3'd2; wr_data = 12'habc; tick("R2");
    rd_en = 1; rd_idx = 3'd2; tick("R2");
    wr_en = 1; wr_idx = 3'd5; wr_data = 12'h123; tick("R2");
    wr_en = 1; wr_idx = 3'd6; wr_data = 12'h456; tick("R2");
    // R3: corrupt bank 1 of index 5, read it
    inj_en = 1; inj_bank_sel = 2'b10; inj_idx = 3'd5; inj_raw = 12'h000; tick("R3");
    rd_en = 1; rd_idx = 3'd5; tick("R3");
    // R4 / R5: corrupt bank 0 of index 6, condition lookup keeps first capture
    inj_en = 1; inj_bank_sel = 2'b01; inj_idx = 3'd6; inj_raw = 12'hfff; tick("R4");
    cond_en = 1; cond_idx = 3'd6; tick("R5");
    cond_en = 1; cond_idx = 3'd2; tick("R4");
    // R6: plain clear, then clear together with a new mismatch
    err_clear = 1; tick("R6");
    rd_en = 1; rd_idx = 3'd2; tick("R6");
    err_clear = 1; rd_en = 1; rd_idx = 3'd6; tick("R6");
    // R7: write and read of corrupted index 5 in one cycle
    err_clear = 1; tick("R6");
    wr_en = 1; wr_idx = 3'd5; wr_data = 12'h777; rd_en = 1; rd_idx = 3'd5; tick("R7");
    // R10: repaired copies stay clean; write beats injection on index 6
    rd_en = 1; rd_idx = 3'd5; tick("R10");
    wr_en = 1; wr_idx = 3'd6; wr_data = 12'h0f0;
    inj_en = 1; inj_bank_sel = 2'b11; inj_idx = 3'd6; inj_raw = 12'h333; tick("R10");
    rd_en = 1; rd_idx = 3'd6; tick("R10");
    // R8: both ports fail in one cycle, read port is captured
    inj_en = 1; inj_bank_sel = 2'b01; inj_idx = 3'd1; inj_raw = 12'h00f; tick("R8");
    inj_en = 1; inj_bank_sel = 2'b10; inj_idx = 3'd3; inj_raw = 12'h0f0; tick("R8");
    rd_en = 1; rd_idx = 3'd1; cond_en = 1; cond_idx = 3'd3; tick("R8");
    err_clear = 1; tick("R8");
    cond_en = 1; cond_idx = 3'd3; tick("R8");
    // R9: same raw pattern forced into both banks still mismatches
    err_clear = 1; wr_en = 1; wr_idx = 3'd4; wr_data = 12'h555; tick("R9");
    inj_en = 1; inj_bank_sel = 2'b11; inj_idx = 3'd4; inj_raw = 12'h555; tick("R9");
    rd_en = 1; rd_idx = 3'd4; tick("R9");
    // R11: corruption that is never read stays silent
    err_clear = 1; tick("R11");
    inj_en = 1; inj_bank_sel = 2'b10; inj_idx = 3'd7; inj_raw = 12'h001; tick("R11");
    for (int k = 0; k < 4; k++) begin
      rd_en = 1; rd_idx = 3'd2; tick("R11");
    end
    chk("R11", "err_flag after unread upset", int'(err_flag), 0);
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      wr_en     = ($urandom_range(3) == 0);
      wr_idx    = IW'($urandom_range(NV-1));
      wr_data   = DW'($urandom);
      rd_en     = ($urandom_range(1) == 0);
      rd_idx    = IW'($urandom_range(NV-1));
      cond_en   = ($urandom_range(2) == 0);
      cond_idx  = IW'($urandom_range(NV-1));
      err_clear = ($urandom_range(15) == 0);
      inj_en    = ($urandom_range(9) == 0);
      inj_bank_sel = 2'($urandom_range(3));
      inj_idx   = IW'($urandom_range(NV-1));
      inj_raw   = DW'($urandom);
      tick("RND");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule